// File: doc/BRIEF.md
# Ternary Bitstream Adder with Carry Feedback

This block adds two ternary sigma-delta bitstreams, one sample per clock. Each operand and the result is a single trit (-1, 0 or +1) carried on two wires. A sum that does not fit in one trit is not simply clipped. The part that overflows is kept in a one-trit carry register and folded into later output samples. This moves the truncation error toward high frequencies, where a later averaging filter removes it.

A mode input chooses between this carry-feedback adder and a plain truncating adder, so the two can be compared on the same streams. A second input negates the second operand, which turns the block into a subtractor. The block has a valid input. It produces one registered result one clock after each valid sample. Samples that are not marked valid leave the result and the carry untouched.

Top module: `tern_stream_adder`

## Requirements
- R1: Trit encoding on every operand and on the result: `00` = 0, `01` = +1, `11` = -1. An input code `10` is read as 0, and the result never carries the code `10`.
- R2: With `improve_mode` = 0 (truncating), the result is the exact sum of the two operands when that sum is -1, 0 or +1. A sum of +2 gives +1 and a sum of -2 gives -1. The overflow is discarded.
- R3: With `improve_mode` = 1, an overflow from adding the two operands is held in the carry register. It is added into the result of the next valid sample.
- R4: With `improve_mode` = 1, if adding the held carry to the operand partial sum overflows again, that second carry is stored for the following valid sample.
- R5: With `improve_mode` = 1, when the operand carry and the second-level carry are equal and nonzero in the same sample, one carry of that sign is stored and the excess is lost.
- R6: With `sub_mode` = 1, the second operand is negated (+1 and -1 swap) before the addition, in both adder modes.
- R7: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. When `in_valid` is low, neither the result nor the stored carry changes.
- R8: A synchronous active-low reset clears the stored carry, `out_valid` and the result to 0.
- R9: A valid sample in truncating mode clears the stored carry. A later switch to carry-feedback mode therefore starts with no pending carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the operand trits of this cycle as a sample |
| sub_mode | input | 1 | 1 = negate the second operand |
| improve_mode | input | 1 | 1 = carry-feedback adder, 0 = truncating adder |
| a_trit | input | 2 | First operand trit |
| b_trit | input | 2 | Second operand trit |
| out_valid | output | 1 | Result trit holds a new sample |
| sum_trit | output | 2 | Result trit |

## Verification
The hardest case to reach from the ports is R5: a carry is already stored, and the next sample carries the same sign on both operands. Random streams hit this only when three like-signed trits line up. A directed sequence therefore drives two +1 samples back to back, then zero samples. The zero samples bring the stored carry out through the result, which shows the excess was dropped. The constrained random phase biases the operands toward equal nonzero pairs. It also keeps each mode setting for several samples, so runs of stacked carries occur with both signs, with subtraction, and around mode switches.

// File: rtl/tsa_pkg.sv
// Package: shared trit type, code constants and conversion helpers.
// Assumes trits are carried on two wires; code 2'b10 is illegal and reads as 0.
package tsa_pkg;

    localparam int TRIT_W = 2;

    typedef logic [TRIT_W-1:0] trit_t;

    localparam trit_t TRIT_ZERO = 2'b00;
    localparam trit_t TRIT_POS  = 2'b01;
    localparam trit_t TRIT_NEG  = 2'b11;

    // Numeric value of a trit code, illegal code read as 0.
    function automatic logic signed [2:0] trit_value(input trit_t t);
        case (t)
            TRIT_POS: trit_value = 3'sd1;
            TRIT_NEG: trit_value = -3'sd1;
            default:  trit_value = 3'sd0;
        endcase
    endfunction

    // Legal code for a trit value in -1..+1 (anything else maps to 0).
    function automatic trit_t trit_code(input logic signed [2:0] v);
        case (v)
            3'sd1:   trit_code = TRIT_POS;
            -3'sd1:  trit_code = TRIT_NEG;
            default: trit_code = TRIT_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/tsa_operand_prep.sv
// Operand preparation: maps the illegal code to 0 and optionally negates.
// Assumes negation only swaps +1 and -1; zero stays zero.
module tsa_operand_prep
    import tsa_pkg::*;
#(
    parameter bit ALLOW_NEGATE = 1'b1
) (
    input  trit_t raw_i,
    input  logic  negate_i,
    output trit_t clean_o
);

    trit_t legal;

    // Normalise the incoming code to a legal trit.
    always_comb legal = trit_code(trit_value(raw_i));

    generate
        if (ALLOW_NEGATE) begin : g_neg
            // Swap the sign when negation is requested.
            always_comb clean_o = negate_i ? trit_code(-trit_value(legal)) : legal;
        end else begin : g_pass
            logic unused_neg;
            // Operand passes unchanged; negate input has no use here.
            always_comb begin
                unused_neg = negate_i;
                clean_o    = legal;
            end
        end
    endgenerate

endmodule

// File: rtl/tsa_half_adder.sv
// Ternary half-adder cell: s + c always equals x + y.
// A total of +2 gives s=+1, c=+1; -2 gives s=-1, c=-1; otherwise c=0.
// Assumes both inputs are legal trit codes.
module tsa_half_adder
    import tsa_pkg::*;
(
    input  trit_t x_i,
    input  trit_t y_i,
    output trit_t s_o,
    output trit_t c_o
);

    logic signed [2:0] total;

    // Split the two-trit total into a result trit and a carry trit.
    always_comb begin
        total = trit_value(x_i) + trit_value(y_i);
        case (total)
            3'sd2: begin
                s_o = TRIT_POS;
                c_o = TRIT_POS;
            end
            -3'sd2: begin
                s_o = TRIT_NEG;
                c_o = TRIT_NEG;
            end
            default: begin
                s_o = trit_code(total);
                c_o = TRIT_ZERO;
            end
        endcase
    end

endmodule

// File: rtl/tsa_carry_reg.sv
// One-trit carry register with synchronous active-low clear and load enable.
// Assumes the loaded value is a legal trit code.
module tsa_carry_reg
    import tsa_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  trit_t d_i,
    output trit_t q_o
);

    // Hold the pending carry between samples.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= TRIT_ZERO;
        else if (load_i) q_o <= d_i;
    end

endmodule

// File: rtl/tern_stream_adder.sv
// Ternary bitstream adder with carry feedback.
// Cell 1 adds the operands. Cell 2 adds that partial sum to the stored carry
// to form the result. Cell 3 merges both carries into the next stored carry
// and drops its own overflow. In truncating mode the result is the cell 1 sum
// and the stored carry is cleared. Result is registered: one cycle latency.
// Assumes operands change only with in_valid; illegal codes read as 0.
module tern_stream_adder
    import tsa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       sub_mode,
    input  logic       improve_mode,
    input  logic [1:0] a_trit,
    input  logic [1:0] b_trit,
    output logic       out_valid,
    output logic [1:0] sum_trit
);

    trit_t a_clean, b_clean;
    trit_t part_sum, carry_ops;
    trit_t fold_sum, carry_fold;
    trit_t next_carry, carry_lost;
    trit_t carry_q, carry_d, result_d;

    tsa_operand_prep #(.ALLOW_NEGATE(1'b0)) i_prep_a (
        .raw_i    (a_trit),
        .negate_i (1'b0),
        .clean_o  (a_clean)
    );

    tsa_operand_prep #(.ALLOW_NEGATE(1'b1)) i_prep_b (
        .raw_i    (b_trit),
        .negate_i (sub_mode),
        .clean_o  (b_clean)
    );

    tsa_half_adder i_cell_ops (
        .x_i (a_clean),
        .y_i (b_clean),
        .s_o (part_sum),
        .c_o (carry_ops)
    );

    tsa_half_adder i_cell_fold (
        .x_i (part_sum),
        .y_i (carry_q),
        .s_o (fold_sum),
        .c_o (carry_fold)
    );

    tsa_half_adder i_cell_merge (
        .x_i (carry_ops),
        .y_i (carry_fold),
        .s_o (next_carry),
        .c_o (carry_lost)
    );

    // Pick result and next carry for the selected adder mode.
    always_comb begin
        result_d = improve_mode ? fold_sum   : part_sum;
        carry_d  = improve_mode ? next_carry : TRIT_ZERO;
    end

    tsa_carry_reg i_carry (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (in_valid),
        .d_i    (carry_d),
        .q_o    (carry_q)
    );

    // Register the result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sum_trit  <= TRIT_ZERO;
        end else begin
            out_valid <= in_valid;
            if (in_valid) sum_trit <= result_d;
        end
    end

    logic unused_lost;
    // Overflow of the merge cell is discarded by design.
    always_comb unused_lost = ^carry_lost;

endmodule

// File: rtl/tsa_checker.sv
// Checker for tern_stream_adder: temporal properties on ports and carry state.
// Assumes it is bound into the top module with carry_q visible.
module tsa_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       sub_mode,
    input logic       improve_mode,
    input logic [1:0] a_trit,
    input logic [1:0] b_trit,
    input logic       out_valid,
    input logic [1:0] sum_trit,
    input logic [1:0] carry_q
);

    // R1: result and stored carry only use legal codes
    a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_trit != 2'b10) && (carry_q != 2'b10));

    // R7: valid follows with one cycle latency
    a_r7_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r7_valid_low: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7: idle samples keep result and carry
    a_r7_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sum_trit) && $stable(carry_q)));

    // R9: truncating samples leave no pending carry
    a_r9_trunc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !improve_mode) |=> (carry_q == 2'b00));

    // R2: two +1 operands clip to +1 in truncating mode
    a_r2_clip_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !improve_mode && !sub_mode && a_trit == 2'b01 && b_trit == 2'b01)
        |=> (sum_trit == 2'b01));

    // R5: stacked +1 carries keep one +1 and drop the excess
    a_r5_excess_lost: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && improve_mode && !sub_mode && a_trit == 2'b01 &&
         b_trit == 2'b01 && carry_q == 2'b01)
        |=> (sum_trit == 2'b01 && carry_q == 2'b01));

    // R8: reset clears every register
    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && sum_trit == 2'b00 && carry_q == 2'b00));

endmodule

bind tern_stream_adder tsa_checker i_tsa_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .sub_mode     (sub_mode),
    .improve_mode (improve_mode),
    .a_trit       (a_trit),
    .b_trit       (b_trit),
    .out_valid    (out_valid),
    .sum_trit     (sum_trit),
    .carry_q      (carry_q)
);

// File: tb/test_tern_stream_adder.sv
`timescale 1ns/1ps
module test_tern_stream_adder;

    localparam real HALF = 2.5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       sub_mode = 1'b0;
    logic       improve_mode = 1'b1;
    logic [1:0] a_trit = 2'b00;
    logic [1:0] b_trit = 2'b00;
    logic       out_valid;
    logic [1:0] sum_trit;

    int checks = 0;
    int errors = 0;
    int m_carry = 0;
    logic [1:0] m_sum = 2'b00;
    bit done = 0;

    tern_stream_adder i_tern_stream_adder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_mode(sub_mode),
        .improve_mode(improve_mode), .a_trit(a_trit), .b_trit(b_trit),
        .out_valid(out_valid), .sum_trit(sum_trit)
    );

    always #(HALF) clk = ~clk;

    function automatic int val(input logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b11) return -1;
        return 0;
    endfunction

    function automatic logic [1:0] enc(input int v);
        if (v == 1) return 2'b01;
        if (v == -1) return 2'b11;
        return 2'b00;
    endfunction

    function automatic int ha_s(input int x, input int y);
        int t = x + y;
        if (t > 1) return 1;
        if (t < -1) return -1;
        return t;
    endfunction

    function automatic int ha_c(input int x, input int y);
        int t = x + y;
        if (t > 1) return 1;
        if (t < -1) return -1;
        return 0;
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, update model, sample after the edge.
    task automatic step(input string tag, input logic v, input logic s,
                        input logic imp, input logic [1:0] a, input logic [1:0] b);
        int av, bv, p, c1, y, c2;
        @(negedge clk);
        in_valid = v; sub_mode = s; improve_mode = imp; a_trit = a; b_trit = b;
        @(posedge clk);
        if (rst_n && v) begin
            av = val(a);
            bv = s ? -val(b) : val(b);
            p  = ha_s(av, bv);
            c1 = ha_c(av, bv);
            y  = ha_s(p, m_carry);
            c2 = ha_c(p, m_carry);
            if (imp) begin
                m_sum   = enc(y);
                m_carry = ha_s(c1, c2);
            end else begin
                m_sum   = enc(p);
                m_carry = 0;
            end
        end
        #1;
        check(tag, {1'b0, out_valid, sum_trit}, {1'b0, v, m_sum});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        m_carry = 0;
        m_sum = 2'b00;
        check("R8 reset", {1'b0, out_valid, sum_trit}, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
    endtask

    initial begin
        #(2.0 * HALF * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] codes [4];
        codes[0] = 2'b00; codes[1] = 2'b01; codes[2] = 2'b11; codes[3] = 2'b10;
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        #1;
        check("R8 initial", {1'b0, out_valid, sum_trit}, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: illegal code reads as zero
        step("R1 illegal a", 1, 0, 0, 2'b10, 2'b01);
        step("R1 illegal both", 1, 0, 0, 2'b10, 2'b10);
        // R2: truncating mode
        step("R2 clip pos", 1, 0, 0, 2'b01, 2'b01);
        step("R2 clip neg", 1, 0, 0, 2'b11, 2'b11);
        step("R2 exact", 1, 0, 0, 2'b01, 2'b11);
        step("R2 carry dropped", 1, 0, 0, 2'b00, 2'b00);
        // R3: stored carry appears in next result
        step("R3 overflow", 1, 0, 1, 2'b01, 2'b01);
        step("R3 carry out", 1, 0, 1, 2'b00, 2'b00);
        step("R3 carry used", 1, 0, 1, 2'b00, 2'b00);
        // R4: second-level overflow stored again
        step("R4 load", 1, 0, 1, 2'b11, 2'b11);
        step("R4 refold", 1, 0, 1, 2'b11, 2'b00);
        step("R4 reveal", 1, 0, 1, 2'b00, 2'b00);
        step("R4 empty", 1, 0, 1, 2'b00, 2'b00);
        // R5: equal nonzero carries lose the excess
        step("R5 load", 1, 0, 1, 2'b01, 2'b01);
        step("R5 stack", 1, 0, 1, 2'b01, 2'b01);
        step("R5 reveal", 1, 0, 1, 2'b00, 2'b00);
        step("R5 empty", 1, 0, 1, 2'b00, 2'b00);
        // R6: subtraction negates b
        step("R6 sub overflow", 1, 1, 1, 2'b01, 2'b11);
        step("R6 sub cancel", 1, 1, 1, 2'b01, 2'b01);
        step("R6 sub trunc", 1, 1, 0, 2'b11, 2'b01);
        // R7: idle cycle keeps carry and result
        step("R7 load", 1, 0, 1, 2'b11, 2'b11);
        step("R7 idle", 0, 0, 1, 2'b01, 2'b01);
        step("R7 idle2", 0, 0, 0, 2'b01, 2'b01);
        step("R7 reveal", 1, 0, 1, 2'b00, 2'b00);
        // R9: truncating sample clears carry
        step("R9 load", 1, 0, 1, 2'b01, 2'b01);
        step("R9 trunc", 1, 0, 0, 2'b00, 2'b00);
        step("R9 no carry", 1, 0, 1, 2'b00, 2'b00);
        // R8: mid-run reset drops a pending carry
        step("R8 load", 1, 0, 1, 2'b01, 2'b01);
        do_reset();
        step("R8 after reset", 1, 0, 1, 2'b00, 2'b00);

        // Random phase, modes held for runs, bias toward equal operands.
        for (int blk = 0; blk < 200; blk++) begin
            logic s = 1'($urandom_range(0, 1));
            logic imp = ($urandom_range(0, 3) != 0);
            for (int k = 0; k < 20; k++) begin
                logic [1:0] a = codes[$urandom_range(0, 3)];
                logic [1:0] b = ($urandom_range(0, 1) != 0) ? a : codes[$urandom_range(0, 3)];
                logic v = ($urandom_range(0, 9) != 0);
                step("R2/R3/R4/R5/R6 random", v, s, imp, a, b);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule